// File: doc/BRIEF.md
# Prioritized Interruption Class Selector

This block decides, at each instruction boundary, which pending interruption class the processor takes next, and produces the information needed to deliver it: a one-hot class select, a 16-bit external interruption code, and the chosen I/O subclass. Synchronous exceptions (program and supervisor call) are always taken first. After them come the asynchronous classes in a fixed ladder: machine check, then external, then I/O. Each asynchronous class is gated by its enable bit in the current program status word (PSW) and by the relevant control-register bits.

The pending flags and the per-subclass I/O queues are held outside the block. When the core acknowledges the registered selection, the block raises clear strobes for the flags that the delivery empties. For queued sources it uses "last entry" hints from the queue owners to decide this. The block also merges the 2-bit condition code into the PSW mask that is saved as the old PSW. Storing and fetching PSWs in memory is done elsewhere.

Top module: `irq_class_sel`

## Requirements
- R1: A pending program exception (pend bit 0) is selected ahead of everything else. A pending supervisor call (pend bit 1) is selected ahead of every asynchronous class. Both are selected regardless of the PSW enable bits.
- R2: The asynchronous classes are ordered machine check (pend bit 2), then external (pend bits 3, 4, 5), then I/O (pend bit 6). Each class is considered only when its enable bit is set in the PSW mask: bit 50 for machine check, bit 56 for external, bit 57 for I/O. The class select bits are: 0 program, 1 supervisor call, 2 machine check, 3 external, 4 I/O.
- R3: Within the external class, the selection order is:
  - a queued external request (pend bit 3) first, with the code taken from `ext_code_i`;
  - then the TOD comparator (pend bit 4), with code 0x1004;
  - then the CPU timer (pend bit 5), with code 0x1005.
  When the class taken is not external, the code output is zero.
- R4: Acknowledging a TOD interruption strobes the clears for pend bits 4 and 3. Acknowledging a CPU-timer interruption strobes the clears for pend bits 5, 4 and 3. Acknowledging a queued external request strobes the clear for bit 3 only when `ext_last_i` is set.
- R5: An enabled, pending machine check is taken only when bit 28 of control register 14 is set. When that bit is clear, nothing at all is selected.
- R6: Among I/O subclasses, the lowest-numbered one is chosen that has a non-empty queue and whose enable bit is set in control register 6. Subclass n is enabled by bit 31-n. If no such subclass exists, nothing is selected.
- R7: On an I/O acknowledge, the I/O clear strobe (bit 6) is raised only when no subclass queue, whether enabled or masked, remains non-empty after the chosen subclass pops. The chosen subclass is empty after the pop only when its `io_last_i` bit is set.
- R8: `old_mask_o` equals `psw_mask_i` with bits 45:44 replaced by `cc_i`.
- R9: `irq_o` is low in the cycle after every pend bit is zero, and high in the cycle after any pend bit is set.
- R10: The selection is registered: it reflects the inputs one clock edge earlier. Clear strobes are combinational from the registered selection while `ack_i` is high. The selection in the cycle after an acknowledge is empty. The class select is one-hot or zero.
- R11: During reset, and on its release, the class select, clear strobes, code, subclass and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | 7 | Pending flags (program, svc, machine check, external, TOD, CPU timer, I/O) |
| io_nonempty_i | input | NSUB | Per-subclass I/O queue non-empty |
| io_last_i | input | NSUB | Per-subclass I/O queue holds exactly one entry |
| ext_last_i | input | 1 | External queue holds exactly one entry |
| mchk_last_i | input | 1 | Machine-check queue holds exactly one entry |
| ext_code_i | input | 16 | Code of the head queued external request |
| psw_mask_i | input | 64 | Current PSW mask |
| cc_i | input | 2 | Current condition code |
| cr6_i | input | 32 | Control register 6, subclass enables |
| cr14_i | input | 32 | Control register 14, machine-check enables |
| ack_i | input | 1 | Core takes the registered selection |
| take_o | output | 5 | One-hot class select |
| ext_code_o | output | 16 | External interruption code |
| io_sub_o | output | SUBW | Chosen I/O subclass |
| clr_o | output | 7 | Pending-clear strobes, same bit order as pend_i |
| irq_o | output | 1 | Interrupt request to the core |
| old_mask_o | output | 64 | PSW mask with condition code merged |

## Verification
The selection ladder is driven with vectors that have several classes pending at once. Each vector differs from another in exactly one enable or control bit, so any misplaced rung or gate changes the expected class. The external sub-order is separated by stacking the queued, TOD and CPU-timer sources and then removing them one at a time. The subclass scan is driven with masks that disable the lowest non-empty subclass, which separates a plain lowest-first search from the masked one. Acknowledges cover each queued source with and without the last-entry hint, and include a masked subclass that is still non-empty.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
    localparam int NPEND   = 7;
    localparam int PB_PGM  = 0;
    localparam int PB_SVC  = 1;
    localparam int PB_MCHK = 2;
    localparam int PB_EXT  = 3;
    localparam int PB_TOD  = 4;
    localparam int PB_CPUT = 5;
    localparam int PB_IO   = 6;

    localparam int NCLS    = 5;
    localparam int CL_PGM  = 0;
    localparam int CL_SVC  = 1;
    localparam int CL_MCHK = 2;
    localparam int CL_EXT  = 3;
    localparam int CL_IO   = 4;

    localparam int PSWB_MCHK = 50;
    localparam int PSWB_EXT  = 56;
    localparam int PSWB_IO   = 57;
    localparam int PSWB_CC   = 44;

    localparam int CR14_MCHK_BIT = 28;
    localparam int CR6_ISC_TOP   = 31;

    localparam logic [15:0] CODE_TOD  = 16'h1004;
    localparam logic [15:0] CODE_CPUT = 16'h1005;

    typedef enum logic [1:0] {
        XS_NONE  = 2'd0,
        XS_QUEUE = 2'd1,
        XS_TOD   = 2'd2,
        XS_CPUT  = 2'd3
    } ext_src_e;
endpackage

// File: rtl/irq_io_scan.sv
module irq_io_scan #(
    parameter  int NSUB = 8,
    localparam int SUBW = (NSUB > 1) ? $clog2(NSUB) : 1
) (
    input  logic [NSUB-1:0] ready_i,
    output logic            hit_o,
    output logic [SUBW-1:0] sub_o
);
    // lowest ready subclass wins: scan downward so the last hit is the lowest
    always_comb begin
        hit_o = 1'b0;
        sub_o = '0;
        for (int n = NSUB - 1; n >= 0; n--) begin
            if (ready_i[n]) begin
                hit_o = 1'b1;
                sub_o = SUBW'(n);
            end
        end
    end
endmodule

// File: rtl/irq_ext_arb.sv
module irq_ext_arb
    import irq_sel_pkg::*;
(
    input  logic        queued_i,
    input  logic        tod_i,
    input  logic        cput_i,
    input  logic [15:0] qcode_i,
    output logic        any_o,
    output ext_src_e    src_o,
    output logic [15:0] code_o
);
    always_comb begin
        any_o  = queued_i | tod_i | cput_i;
        src_o  = XS_NONE;
        code_o = '0;
        if (queued_i) begin
            src_o  = XS_QUEUE;
            code_o = qcode_i;
        end else if (tod_i) begin
            src_o  = XS_TOD;
            code_o = CODE_TOD;
        end else if (cput_i) begin
            src_o  = XS_CPUT;
            code_o = CODE_CPUT;
        end
    end
endmodule

// File: rtl/irq_cc_merge.sv
module irq_cc_merge
    import irq_sel_pkg::*;
(
    input  logic [63:0] psw_i,
    input  logic [1:0]  cc_i,
    output logic [63:0] old_o
);
    localparam logic [63:0] CC_FIELD = 64'h3 << PSWB_CC;

    always_comb begin
        old_o = (psw_i & ~CC_FIELD) | (64'(cc_i) << PSWB_CC);
    end
endmodule

// File: rtl/irq_class_sel.sv
module irq_class_sel
    import irq_sel_pkg::*;
#(
    parameter  int NSUB = 8,
    localparam int SUBW = (NSUB > 1) ? $clog2(NSUB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPEND-1:0] pend_i,
    input  logic [NSUB-1:0]  io_nonempty_i,
    input  logic [NSUB-1:0]  io_last_i,
    input  logic             ext_last_i,
    input  logic             mchk_last_i,
    input  logic [15:0]      ext_code_i,
    input  logic [63:0]      psw_mask_i,
    input  logic [1:0]       cc_i,
    input  logic [31:0]      cr6_i,
    input  logic [31:0]      cr14_i,
    input  logic             ack_i,
    output logic [NCLS-1:0]  take_o,
    output logic [15:0]      ext_code_o,
    output logic [SUBW-1:0]  io_sub_o,
    output logic [NPEND-1:0] clr_o,
    output logic             irq_o,
    output logic [63:0]      old_mask_o
);
    typedef struct packed {
        logic [NCLS-1:0] cls;
        ext_src_e        xsrc;
        logic [15:0]     code;
        logic [SUBW-1:0] sub;
        logic            irq;
    } sel_t;

    sel_t s_d, s_q;

    logic [NSUB-1:0] io_en;
    logic [NSUB-1:0] io_ready;
    logic            io_hit;
    logic [SUBW-1:0] io_sub;
    logic            ext_any;
    ext_src_e        ext_src;
    logic [15:0]     ext_code;
    logic [NSUB-1:0] pop_vec;
    logic [NSUB-1:0] io_left;

    // subclass n is enabled by the control-register bit counted from the top
    for (genvar n = 0; n < NSUB; n++) begin : g_isc
        assign io_en[n] = cr6_i[CR6_ISC_TOP - n];
    end
    assign io_ready = io_nonempty_i & io_en;

    irq_io_scan #(.NSUB(NSUB)) u_scan (
        .ready_i (io_ready),
        .hit_o   (io_hit),
        .sub_o   (io_sub)
    );

    irq_ext_arb u_ext (
        .queued_i (pend_i[PB_EXT]),
        .tod_i    (pend_i[PB_TOD]),
        .cput_i   (pend_i[PB_CPUT]),
        .qcode_i  (ext_code_i),
        .any_o    (ext_any),
        .src_o    (ext_src),
        .code_o   (ext_code)
    );

    irq_cc_merge u_cc (
        .psw_i (psw_mask_i),
        .cc_i  (cc_i),
        .old_o (old_mask_o)
    );

    // next selection: fixed ladder, blanked in the acknowledge cycle
    always_comb begin
        s_d      = '0;
        s_d.xsrc = XS_NONE;
        s_d.irq  = |pend_i;
        if (!ack_i) begin
            if (pend_i[PB_PGM]) begin
                s_d.cls[CL_PGM] = 1'b1;
            end else if (pend_i[PB_SVC]) begin
                s_d.cls[CL_SVC] = 1'b1;
            end else if (psw_mask_i[PSWB_MCHK] && pend_i[PB_MCHK]) begin
                // a gated machine check holds off every lower class
                if (cr14_i[CR14_MCHK_BIT]) s_d.cls[CL_MCHK] = 1'b1;
            end else if (psw_mask_i[PSWB_EXT] && ext_any) begin
                s_d.cls[CL_EXT] = 1'b1;
                s_d.xsrc        = ext_src;
                s_d.code        = ext_code;
            end else if (psw_mask_i[PSWB_IO] && pend_i[PB_IO] && io_hit) begin
                s_d.cls[CL_IO] = 1'b1;
                s_d.sub        = io_sub;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // queue state after the chosen subclass pops
    assign pop_vec = s_q.cls[CL_IO] ? (NSUB'(1) << s_q.sub) : '0;
    assign io_left = io_nonempty_i & ~(pop_vec & io_last_i);

    always_comb begin
        clr_o = '0;
        if (ack_i) begin
            if (s_q.cls[CL_PGM])  clr_o[PB_PGM]  = 1'b1;
            if (s_q.cls[CL_SVC])  clr_o[PB_SVC]  = 1'b1;
            if (s_q.cls[CL_MCHK]) clr_o[PB_MCHK] = mchk_last_i;
            if (s_q.cls[CL_EXT]) begin
                case (s_q.xsrc)
                    XS_QUEUE: clr_o[PB_EXT] = ext_last_i;
                    XS_TOD: begin
                        clr_o[PB_TOD] = 1'b1;
                        clr_o[PB_EXT] = 1'b1;
                    end
                    XS_CPUT: begin
                        clr_o[PB_CPUT] = 1'b1;
                        clr_o[PB_TOD]  = 1'b1;
                        clr_o[PB_EXT]  = 1'b1;
                    end
                    default: clr_o = '0;
                endcase
            end
            if (s_q.cls[CL_IO]) clr_o[PB_IO] = ~|io_left;
        end
    end

    assign take_o     = s_q.cls;
    assign ext_code_o = s_q.code;
    assign io_sub_o   = s_q.sub;
    assign irq_o      = s_q.irq;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_o)); // R10
    AST_ACK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (take_o == '0)); // R10
    AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && pend_i[PB_PGM]) |=> take_o[CL_PGM]); // R1
    AST_MCHK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !cr14_i[CR14_MCHK_BIT] |=> !take_o[CL_MCHK]); // R5
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |=> !irq_o); // R9
    AST_TIMER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o[PB_CPUT] |-> (clr_o[PB_TOD] && clr_o[PB_EXT])); // R4
    AST_TOD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o[CL_EXT] && s_q.xsrc == XS_TOD) |-> (ext_code_o == CODE_TOD)); // R3
    AST_IO_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> io_en[io_sub]); // R6
endmodule

// File: tb/irq_class_sel_bench.sv
module irq_class_sel_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  pend = '0;
    logic [7:0]  io_ne = '0;
    logic [7:0]  io_last = '0;
    logic        ext_last = 1'b0;
    logic        mchk_last = 1'b0;
    logic [15:0] qcode = '0;
    logic [63:0] psw = '0;
    logic [1:0]  cc = '0;
    logic [31:0] cr6 = '0;
    logic [31:0] cr14 = '0;
    logic        ack = 1'b0;
    logic [4:0]  take;
    logic [15:0] code;
    logic [2:0]  sub;
    logic [6:0]  clr;
    logic        irq;
    logic [63:0] old_mask;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [4:0]  q_cls[$];
    logic [15:0] q_code[$];
    logic [2:0]  q_sub[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_class_sel u_irq_class_sel (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .io_nonempty_i(io_ne),
        .io_last_i(io_last), .ext_last_i(ext_last), .mchk_last_i(mchk_last),
        .ext_code_i(qcode), .psw_mask_i(psw), .cc_i(cc), .cr6_i(cr6),
        .cr14_i(cr14), .ack_i(ack), .take_o(take), .ext_code_o(code),
        .io_sub_o(sub), .clr_o(clr), .irq_o(irq), .old_mask_o(old_mask)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model of the selection ladder, written from the requirements
    task automatic model(output logic [4:0] c, output logic [15:0] k, output logic [2:0] s);
        c = '0; k = '0; s = '0;
        if (pend[0]) c = 5'b00001;
        else if (pend[1]) c = 5'b00010;
        else if (psw[50] && pend[2]) c = cr14[28] ? 5'b00100 : 5'b00000;
        else if (psw[56] && (pend[3] || pend[4] || pend[5])) begin
            c = 5'b01000;
            k = pend[3] ? qcode : (pend[4] ? 16'h1004 : 16'h1005);
        end else if (psw[57] && pend[6]) begin
            for (int n = 7; n >= 0; n--)
                if (io_ne[n] && cr6[31-n]) begin
                    c = 5'b10000;
                    s = 3'(n);
                end
        end
    endtask

    task automatic push(input logic [6:0] p, input logic [63:0] m, input logic [7:0] ne,
                        input logic [31:0] c6, input logic [31:0] c14,
                        input logic [15:0] qc, input string tag);
        logic [4:0] ec; logic [15:0] ek; logic [2:0] es;
        @(negedge clk); #1;
        pend = p; psw = m; io_ne = ne; cr6 = c6; cr14 = c14; qcode = qc;
        model(ec, ek, es);
        q_cls.push_back(ec); q_code.push_back(ek); q_sub.push_back(es); q_tag.push_back(tag);
    endtask

    // monitor: result appears one edge after the driver applied the vector
    always @(negedge clk) begin
        if (q_cls.size() > 0) begin
            logic [4:0] ec; logic [15:0] ek; logic [2:0] es; string t;
            ec = q_cls.pop_front(); ek = q_code.pop_front();
            es = q_sub.pop_front(); t = q_tag.pop_front();
            check(take == ec, {t, " class"}, 64'(take), 64'(ec));
            check(code == ek, {t, " code"}, 64'(code), 64'(ek));
            check(sub == es, {t, " subclass"}, 64'(sub), 64'(es));
        end
    end

    localparam logic [63:0] EN_ALL = (64'h1 << 50) | (64'h1 << 56) | (64'h1 << 57);
    localparam logic [63:0] EN_EXT_IO = (64'h1 << 56) | (64'h1 << 57);
    localparam logic [31:0] MC_ON = 32'h1000_0000;

    task automatic settle();
        @(negedge clk); #1;
        pend = '0; io_ne = '0; io_last = '0; ack = 1'b0;
        @(negedge clk); #1;
    endtask

    // one acknowledge: apply, wait an edge, check selection, pulse ack, check strobes
    task automatic ack_case(input logic [6:0] p, input logic [7:0] ne, input logic [7:0] lst,
                            input logic [6:0] exp_clr, input string tag);
        @(negedge clk); #1;
        pend = p; io_ne = ne; io_last = lst;
        @(negedge clk); #1;
        ack = 1'b1; #1;
        check(clr == exp_clr, {tag, " clear strobes"}, 64'(clr), 64'(exp_clr));
        @(negedge clk); #1;
        check(take == 5'b0, "R10 selection empty after ack", 64'(take), 64'h0);
        ack = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(take == 5'b0 && irq == 1'b0 && clr == 7'b0, "R11 reset state",
              {50'b0, irq, clr, take}, 64'h0);
        check(code == 16'h0 && sub == 3'h0, "R11 reset code/subclass",
              {45'b0, sub, code}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(take == 5'b0 && irq == 1'b0, "R11 state after release",
              {58'b0, irq, take}, 64'h0);

        // R8 condition-code merge
        psw = 64'hFFFF_FFFF_FFFF_FFFF; cc = 2'b01; #1;
        check(old_mask == 64'hFFFF_DFFF_FFFF_FFFF, "R8 cc merge ones", old_mask,
              64'hFFFF_DFFF_FFFF_FFFF);
        psw = 64'h0; cc = 2'b10; #1;
        check(old_mask == 64'h0000_2000_0000_0000, "R8 cc merge zeros", old_mask,
              64'h0000_2000_0000_0000);

        // scoreboard vectors
        push(7'b1111111, EN_ALL, 8'hFF, 32'hFF00_0000, MC_ON, 16'h0040, "R1 program first");
        push(7'b1111110, EN_ALL, 8'hFF, 32'hFF00_0000, MC_ON, 16'h0040, "R1 svc over async");
        push(7'b0000010, 64'h0, 8'h00, 32'h0, 32'h0, 16'h0, "R1 svc with no enables");
        push(7'b1111100, EN_ALL, 8'hFF, 32'hFF00_0000, MC_ON, 16'h0040, "R2 mchk first");
        push(7'b1111100, EN_EXT_IO, 8'hFF, 32'hFF00_0000, MC_ON, 16'h0040, "R2 mchk disabled, ext");
        push(7'b1111100, EN_ALL, 8'hFF, 32'hFF00_0000, 32'h0, 16'h0040, "R5 mchk gated blocks all");
        push(7'b0111000, EN_ALL, 8'h00, 32'h0, MC_ON, 16'h0ABC, "R3 queued ext wins");
        push(7'b0110000, EN_ALL, 8'h00, 32'h0, MC_ON, 16'h0ABC, "R3 TOD code");
        push(7'b0100000, EN_ALL, 8'h00, 32'h0, MC_ON, 16'h0ABC, "R3 cpu timer code");
        push(7'b1111000, 64'h1 << 57, 8'h01, 32'h8000_0000, MC_ON, 16'h0, "R2 ext disabled, io");
        push(7'b1000000, EN_ALL, 8'h0A, 32'h1000_0000, MC_ON, 16'h0, "R6 masked low subclass skipped");
        push(7'b1000000, EN_ALL, 8'hFF, 32'hFF00_0000, MC_ON, 16'h0, "R6 subclass 0");
        push(7'b1000000, EN_ALL, 8'h80, 32'h0100_0000, MC_ON, 16'h0, "R6 subclass 7");
        push(7'b1000000, EN_ALL, 8'h0F, 32'h00F0_0000, MC_ON, 16'h0, "R6 none enabled");
        push(7'b1000000, 64'h1 << 56, 8'hFF, 32'hFF00_0000, MC_ON, 16'h0, "R2 io disabled");
        settle();

        // R9 interrupt request follows pending flags one edge later
        pend = 7'b0100000; psw = 64'h0;
        @(negedge clk); #1;
        check(irq == 1'b1, "R9 irq raised", 64'(irq), 64'h1);
        pend = 7'b0;
        @(negedge clk); #1;
        check(irq == 1'b0, "R9 irq dropped", 64'(irq), 64'h0);

        // acknowledges and clear strobes
        psw = EN_ALL; cr14 = MC_ON; cr6 = 32'h2000_0000;
        ack_case(7'b0010000, 8'h00, 8'h00, 7'b0011000, "R4 TOD");
        ack_case(7'b0100000, 8'h00, 8'h00, 7'b0111000, "R4 cpu timer");
        ext_last = 1'b0;
        ack_case(7'b0001000, 8'h00, 8'h00, 7'b0000000, "R4 queued ext not last");
        ext_last = 1'b1;
        ack_case(7'b0001000, 8'h00, 8'h00, 7'b0001000, "R4 queued ext last");
        mchk_last = 1'b1;
        ack_case(7'b0000100, 8'h00, 8'h00, 7'b0000100, "R10 mchk last");
        ack_case(7'b0000001, 8'h00, 8'h00, 7'b0000001, "R1 program ack");
        ack_case(7'b1000000, 8'h24, 8'h04, 7'b0000000, "R7 masked queue remains");
        ack_case(7'b1000000, 8'h04, 8'h00, 7'b0000000, "R7 chosen queue not last");
        ack_case(7'b1000000, 8'h04, 8'h04, 7'b1000000, "R7 all queues drained");
        settle();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule